// File: doc/BRIEF.md
# Selectable G.711 Compander

This block converts between linear two's-complement audio samples and 8-bit companded codes in both directions at once. An encoder path turns a linear sample into an 8-bit code whose most significant bit is the sign, ready to be shifted out sign first. A decoder path turns an 8-bit code back into a linear sample at the centre of the quantization interval that the code names.

A single datapath serves both companding laws. A select input picks mu-law (level 0) or A-law (level 1). The select is registered and resets to mu-law, which models a select pin that is pulled down and left undriven. The linear width is a parameter (14 or 16 bits). Narrower samples are aligned to the top of a 16-bit internal scale. Each path is one register stage, with a valid strobe in and a valid strobe out.

Top module: `g711_codec`

## Requirements
- R1: The law select is registered, and its reset value is 0. A sample presented in the first cycle after reset is therefore coded as mu-law whatever level `law_sel_i` has. After that, a level of 0 selects mu-law and a level of 1 selects A-law, starting one cycle after the change.
- R2: mu-law encoding yields code 0x80 for positive full scale, 0xFF for zero, 0x7F for -1 (negative zero) and 0x00 for negative full scale. Mid-range codes are the bitwise inverse of {sign(1=negative), segment[2:0], step[3:0]}, found after a bias of 33 is added on the 14-bit scale.
- R3: A-law encoding yields 0xAA for positive full scale, 0xD5 for zero, 0x55 for -1 and 0x2A for negative full scale. Codes are {sign(1=non-negative), segment, step} XOR 0x55, which inverts bits 0, 2, 4 and 6. The magnitude is 13 bits, and segments 0 and 1 share a step size of 2.
- R4: A linear magnitude beyond the largest codable value saturates to the full-scale code of its sign. It never wraps.
- R5: `enc_valid_o` is `enc_valid_i` delayed by one clock, and `enc_code_o` is the code of the sample accepted at that edge.
- R6: `dec_valid_o` is `dec_valid_i` delayed by one clock, and `dec_sample_o` is the decode of the code accepted at that edge.
- R7: The decoder returns the midpoint of the interval on the 16-bit scale. For mu-law, 0x80 gives +32124, 0x00 gives -32124, 0xFF and 0x7F give 0, and 0xCE gives 988. For A-law, 0xAA gives +32256, 0x2A gives -32256, 0xD5 gives +8, 0x55 gives -8, 0xCA gives 504 and 0xD9 gives 200. A 14-bit instance returns these values shifted right by 2.
- R8: Bit 7 of every code is the sign. It is 1 for non-negative samples under both laws. A decoded code with bit 7 set is never negative.
- R9: While a path's input valid is low, its output data holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| law_sel_i | input | 1 | 0 = mu-law, 1 = A-law |
| enc_valid_i | input | 1 | Linear sample valid |
| enc_sample_i | input | LIN_W | Linear two's-complement sample |
| enc_valid_o | output | 1 | Code valid |
| enc_code_o | output | 8 | Companded code, sign in bit 7 |
| dec_valid_i | input | 1 | Code valid |
| dec_code_i | input | 8 | Companded code |
| dec_valid_o | output | 1 | Linear sample valid |
| dec_sample_o | output | LIN_W | Reconstructed linear sample |

## Verification
The hardest situation to reach from the ports is the reset default of the law select. It only shows in the very first sample after reset, and only while the select pin is already driven to A-law. The stimulus holds the select at 1 through reset and presents a zero sample on the edge where reset releases. It then expects the mu-law zero code, and on the next sample the A-law zero code. Saturation needs the most negative input, whose magnitude is one past the largest codable value. The vector table covers it for both laws, along with the segment 0/1 boundary of A-law.

// File: rtl/g711_pkg.sv
package g711_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned INT_W  = 16;
  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;
  localparam logic [CODE_W-1:0] A_XOR_MASK = 8'h55;
  localparam int unsigned MU_BIAS = 33;
  localparam int unsigned MU_CLIP = 8158;
  localparam int unsigned A_CLIP  = 4095;
endpackage

// File: rtl/g711_msb.sv
module g711_msb #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++)
      if (vec_i[i]) idx_o = IW'(i);
  end
endmodule

// File: rtl/g711_enc.sv
module g711_enc
  import g711_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  law_e              law_i,
  input  logic              valid_i,
  input  logic [INT_W-1:0]  sample_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  logic        neg;
  logic [16:0] mag;
  logic [14:0] mu_m14;
  logic [12:0] mu_clip, mu_b, mu_sh;
  logic [13:0] a_m13;
  logic [11:0] a_clip, a_sh;
  logic [2:0]  mu_seg, a_seg;
  logic [3:0]  mu_mant, a_mant;
  logic [CODE_W-1:0] mu_code, a_code, code_d;

  assign neg    = sample_i[INT_W-1];
  assign mag    = neg ? (~{sample_i[INT_W-1], sample_i} + 17'd1) : {1'b0, sample_i};
  assign mu_m14 = mag[16:2];
  assign a_m13  = mag[16:3];
  assign mu_clip = (mu_m14 > 15'(MU_CLIP)) ? 13'(MU_CLIP) : mu_m14[12:0];
  assign mu_b    = mu_clip + 13'(MU_BIAS);
  assign a_clip  = (a_m13 > 14'(A_CLIP)) ? 12'(A_CLIP) : a_m13[11:0];

  g711_msb #(.W(8)) u_mu_seg (.vec_i(mu_b[12:5]),            .idx_o(mu_seg));
  g711_msb #(.W(8)) u_a_seg  (.vec_i({a_clip[11:5], 1'b1}), .idx_o(a_seg));

  assign mu_sh   = mu_b >> ({1'b0, mu_seg} + 4'd1);
  assign mu_mant = mu_sh[3:0];
  assign a_sh    = a_clip >> ((a_seg == 3'd0) ? 4'd1 : {1'b0, a_seg});
  assign a_mant  = a_sh[3:0];

  assign mu_code = ~{neg, mu_seg, mu_mant};
  assign a_code  = {~neg, a_seg, a_mant} ^ A_XOR_MASK;
  assign code_d  = (law_i == LAW_A) ? a_code : mu_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= code_d;
    end
  end

  assert_enc_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_enc_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_enc_sign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (code_o[7] == !$past(sample_i[INT_W-1])));
  assert_enc_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(code_o));
  assert_enc_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sample_i == 16'h8000) |=> (code_o == ($past(law_i) == LAW_A ? 8'h2A : 8'h00)));
endmodule

// File: rtl/g711_dec.sv
module g711_dec
  import g711_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  law_e              law_i,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [INT_W-1:0]  sample_o
);
  logic [7:0]  mu_raw, a_raw;
  logic [15:0] mu_t, mu_mag, a_mag, mag;
  logic        neg;
  logic [15:0] sample_d;

  assign mu_raw = ~code_i;
  assign a_raw  = code_i ^ A_XOR_MASK;
  assign mu_t   = (16'({mu_raw[3:0], 3'b000}) + 16'd132) << mu_raw[6:4];
  assign mu_mag = mu_t - 16'd132;
  assign a_mag  = (a_raw[6:4] == 3'd0) ? (16'({a_raw[3:0], 4'b0000}) + 16'd8)
                : ((16'({a_raw[3:0], 4'b0000}) + 16'h108) << (a_raw[6:4] - 3'd1));
  assign mag      = (law_i == LAW_A) ? a_mag : mu_mag;
  assign neg      = (law_i == LAW_A) ? ~a_raw[7] : mu_raw[7];
  assign sample_d = neg ? (~mag + 16'd1) : mag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sample_o <= sample_d;
    end
  end

  assert_dec_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_dec_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_dec_sign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && code_i[7]) |=> !sample_o[INT_W-1]);
  assert_dec_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sample_o));
endmodule

// File: rtl/g711_codec.sv
module g711_codec
  import g711_pkg::*;
#(
  parameter int unsigned LIN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              law_sel_i,
  input  logic              enc_valid_i,
  input  logic [LIN_W-1:0]  enc_sample_i,
  output logic              enc_valid_o,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [LIN_W-1:0]  dec_sample_o
);
  localparam int unsigned PAD = INT_W - LIN_W;

  law_e             law_q;
  logic [INT_W-1:0] enc_x, dec_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) law_q <= LAW_MU;
    else         law_q <= law_e'(law_sel_i);
  end

  generate
    if (PAD == 0) begin : g_full
      assign enc_x = enc_sample_i;
    end else begin : g_pad
      assign enc_x = {enc_sample_i, {PAD{1'b0}}};
    end
  endgenerate
  assign dec_sample_o = dec_y[INT_W-1 -: LIN_W];

  g711_enc u_enc (
    .clk_i, .rst_ni, .law_i(law_q),
    .valid_i(enc_valid_i), .sample_i(enc_x),
    .valid_o(enc_valid_o), .code_o(enc_code_o)
  );

  g711_dec u_dec (
    .clk_i, .rst_ni, .law_i(law_q),
    .valid_i(dec_valid_i), .code_i(dec_code_i),
    .valid_o(dec_valid_o), .sample_o(dec_y)
  );

  initial assert (LIN_W == 14 || LIN_W == 16) else $error("LIN_W must be 14 or 16");
endmodule

// File: tb/sim_g711_codec.sv
module sim_g711_codec;
  logic clk = 0, rst_ni = 0;
  logic law_sel = 0, enc_v = 0, dec_v = 0;
  logic [15:0] enc_s = '0;
  logic [7:0]  dec_c = '0;
  logic enc_vo, dec_vo;
  logic [7:0]  enc_co;
  logic [15:0] dec_so;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  g711_codec #(.LIN_W(16)) u0 (
    .clk_i(clk), .rst_ni, .law_sel_i(law_sel),
    .enc_valid_i(enc_v), .enc_sample_i(enc_s), .enc_valid_o(enc_vo), .enc_code_o(enc_co),
    .dec_valid_i(dec_v), .dec_code_i(dec_c), .dec_valid_o(dec_vo), .dec_sample_o(dec_so)
  );

  // {req[3:0], dir(0 enc, 1 dec), law, input[15:0], expected[15:0]}
  localparam int NV = 28;
  localparam logic [37:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 16'h0000, 16'h00FF},  // R2 zero
    {4'd2, 1'b0, 1'b0, 16'h7FFF, 16'h0080},  // R2 +full
    {4'd4, 1'b0, 1'b0, 16'h8000, 16'h0000},  // R4 saturate
    {4'd2, 1'b0, 1'b0, 16'hFFFF, 16'h007F},  // R2 -zero
    {4'd2, 1'b0, 1'b0, 16'h03E8, 16'h00CE},  // R2 +1000
    {4'd8, 1'b0, 1'b0, 16'hFC18, 16'h004E},  // R8 -1000
    {4'd3, 1'b0, 1'b1, 16'h0000, 16'h00D5},  // R3
    {4'd3, 1'b0, 1'b1, 16'h7FFF, 16'h00AA},  // R3
    {4'd4, 1'b0, 1'b1, 16'h8000, 16'h002A},  // R4
    {4'd3, 1'b0, 1'b1, 16'hFFFF, 16'h0055},  // R3
    {4'd3, 1'b0, 1'b1, 16'h03E8, 16'h00FA},  // R3 seg2
    {4'd8, 1'b0, 1'b1, 16'hFC18, 16'h007A},  // R8
    {4'd3, 1'b0, 1'b1, 16'h00C8, 16'h00D9},  // R3 seg0
    {4'd3, 1'b0, 1'b1, 16'h01F4, 16'h00CA},  // R3 seg1
    {4'd7, 1'b1, 1'b0, 16'h0080, 16'h7D7C},  // R7
    {4'd7, 1'b1, 1'b0, 16'h0000, 16'h8284},  // R7
    {4'd7, 1'b1, 1'b0, 16'h00FF, 16'h0000},  // R7
    {4'd7, 1'b1, 1'b0, 16'h007F, 16'h0000},  // R7
    {4'd7, 1'b1, 1'b0, 16'h00CE, 16'h03DC},  // R7
    {4'd8, 1'b1, 1'b0, 16'h004E, 16'hFC24},  // R8
    {4'd7, 1'b1, 1'b1, 16'h00AA, 16'h7E00},  // R7
    {4'd7, 1'b1, 1'b1, 16'h002A, 16'h8200},  // R7
    {4'd7, 1'b1, 1'b1, 16'h00D5, 16'h0008},  // R7
    {4'd7, 1'b1, 1'b1, 16'h0055, 16'hFFF8},  // R7
    {4'd7, 1'b1, 1'b1, 16'h00FA, 16'h03F0},  // R7
    {4'd7, 1'b1, 1'b1, 16'h00CA, 16'h01F8},  // R7
    {4'd7, 1'b1, 1'b1, 16'h00D9, 16'h00C8},  // R7
    {4'd1, 1'b0, 1'b0, 16'h0000, 16'h00FF}   // R1 back to mu
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    law_sel = 1;
    repeat (3) @(negedge clk);
    // reset state
    check("R5 reset", {15'd0, enc_vo}, 16'd0);
    check("R6 reset", {15'd0, dec_vo}, 16'd0);
    check("R1 reset code", {8'd0, enc_co}, 16'd0);
    // R1: first sample after reset is mu-law though select is 1
    rst_ni = 1; enc_v = 1; enc_s = 16'h0000;
    @(negedge clk);
    check("R1 default mu", {8'd0, enc_co}, 16'h00FF);
    @(negedge clk);
    check("R1 select A", {8'd0, enc_co}, 16'h00D5);
    enc_v = 0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq; logic dir, lw; logic [15:0] din, exp;
      {rq, dir, lw, din, exp} = VEC[i];
      law_sel = lw;
      @(negedge clk);
      if (dir) begin dec_v = 1; dec_c = din[7:0]; end
      else     begin enc_v = 1; enc_s = din; end
      @(negedge clk);
      enc_v = 0; dec_v = 0;
      if (dir) begin
        check($sformatf("R%0d dec vec %0d", rq, i), dec_so, exp);
        check("R6 valid", {15'd0, dec_vo}, 16'd1);
        dec_c = ~din[7:0];
      end else begin
        check($sformatf("R%0d enc vec %0d", rq, i), {8'd0, enc_co}, exp);
        check("R5 valid", {15'd0, enc_vo}, 16'd1);
        enc_s = ~din;
      end
      @(negedge clk);
      if (dir) begin
        check("R6 idle", {15'd0, dec_vo}, 16'd0);
        check("R9 dec hold", dec_so, exp);
      end else begin
        check("R5 idle", {15'd0, enc_vo}, 16'd0);
        check("R9 enc hold", {8'd0, enc_co}, exp);
      end
    end

    // back-to-back samples, both paths together (R5, R6)
    law_sel = 0;
    @(negedge clk);
    enc_v = 1; enc_s = 16'h7FFF; dec_v = 1; dec_c = 8'h80;
    @(negedge clk);
    check("R5 b2b 1", {8'd0, enc_co}, 16'h0080);
    check("R6 b2b 1", dec_so, 16'h7D7C);
    enc_s = 16'h8000; dec_c = 8'h00;
    @(negedge clk);
    check("R4 b2b 2", {8'd0, enc_co}, 16'h0000);
    check("R6 b2b 2", dec_so, 16'h8284);
    enc_v = 0; dec_v = 0;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule